// File: doc/BRIEF.md
# Rate-Selectable Instruction Frame Sequencer

This block steps the instruction program counter of a DSP core once per core clock and marks the first instruction of each audio sample period with a one-cycle pulse. A two-bit rate select sets how many instructions make up one sample frame: 512 at the base rate, 256 at double rate, and 128 at quad rate. A third output reports which rate is in force, so that the converter clocking can follow it. The base rate suits 44.1 kHz and 48 kHz sampling. The double and quad rates correspond to converters running at nominally 96 kHz and 192 kHz.

The core runs only while the active-low clear input, `core_run`, is 1. Its reset value is 0. While it is 0 the counter is held at zero and no frame pulses appear. A new rate select takes effect only when the current frame wraps, so a frame is never cut short or stretched. The fourth code of the rate select is reserved and behaves as the base rate.

Top module: `frame_sequencer`

## Requirements
- R1: With `rate_sel` = 2'b00 the counter runs 0, 1, …, 511, returns to 0, and repeats, giving a 512-cycle frame.
- R2: With `rate_sel` = 2'b01 the frame is 256 cycles long, so the counter wraps after 255.
- R3: With `rate_sel` = 2'b10 the frame is 128 cycles long, so the counter wraps after 127.
- R4: The reserved code `rate_sel` = 2'b11 gives the same 512-cycle frame as 2'b00, and `conv_rate` reads 2'b00 while it is in force.
- R5: `frame_start` is 1 in exactly those cycles where `core_run` is 1, `rst_n` is 1, and `pc` is 0.
- R6: A change of `rate_sel` in the middle of a frame has no effect until that frame has run to its old last count. The new length applies from the next frame.
- R7: While `core_run` is 0, `pc` goes to 0 at the next clock edge and stays there, and `frame_start` is 0. While it is held, the active rate follows `rate_sel`, so the first frame after release uses the rate selected at that time.
- R8: `conv_rate` gives the active converter rate: 2'b00 for base, 2'b01 for double, 2'b10 for quad. It never reads 2'b11.
- R9: After a synchronous reset (`rst_n` = 0 at a clock edge) `pc` is 0 and `frame_start` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_sel | input | 2 | Rate select: 00 base, 01 double, 10 quad, 11 reserved (treated as base) |
| core_run | input | 1 | Active-low clear: 0 holds the core cleared, 1 lets it run |
| pc | output | 9 | Instruction program counter within the frame |
| frame_start | output | 1 | One-cycle pulse on the first instruction of each frame |
| conv_rate | output | 2 | Active converter rate, encoded like `rate_sel` without the reserved code |

## Verification
A corrupted active-rate register shows up in two ways. `conv_rate` is wrong at once, and the next wrap comes at the wrong count. A 128-cycle frame that should be 512 cycles long, for example, produces a `frame_start` pulse 384 cycles early. A counter that skips or sticks breaks the one-per-cycle step on the next edge. A hold path that fails lets `pc` leave 0 one edge after `core_run` falls. The bench compares `pc`, `frame_start` and `conv_rate` against a model every cycle, so each such fault is reported in the cycle it first shows at the ports.

// File: rtl/frame_seq_pkg.sv
// Package: shared rate encoding and frame length helper for the frame sequencer.
// Assumes the base frame length is a power of two, so that each higher rate halves it.
package frame_seq_pkg;

    typedef enum logic [1:0] {
        RATE_X1   = 2'd0,
        RATE_X2   = 2'd1,
        RATE_X4   = 2'd2,
        RATE_RSVD = 2'd3
    } rate_t;

    // Instructions per frame for a decoded rate, given the base length.
    function automatic int unsigned frame_len(int unsigned base, rate_t r);
        return base >> int'(r);
    endfunction

endpackage

// File: rtl/rate_decode.sv
// Module: rate_decode
// Maps the two-bit rate select onto a legal rate. Assumes the reserved code
// should behave as the base rate. RSVD_AS_BASE=0 instead maps it to the
// fastest rate (a variant that other integrations may pick).
module rate_decode
    import frame_seq_pkg::*;
#(
    parameter bit RSVD_AS_BASE = 1'b1
) (
    input  logic [1:0] code_in,
    output rate_t      rate_out
);

    generate
        if (RSVD_AS_BASE) begin : g_rsvd_base
            // Purpose: legal codes pass through, the reserved code becomes base.
            always_comb begin
                case (code_in)
                    2'b01:   rate_out = RATE_X2;
                    2'b10:   rate_out = RATE_X4;
                    default: rate_out = RATE_X1;
                endcase
            end
        end else begin : g_rsvd_fast
            // Purpose: legal codes pass through, the reserved code becomes quad.
            always_comb begin
                case (code_in)
                    2'b00:   rate_out = RATE_X1;
                    2'b01:   rate_out = RATE_X2;
                    default: rate_out = RATE_X4;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/rate_holder.sv
// Module: rate_holder
// Holds the rate in force for the current frame. It reloads from the decoded
// select only at a frame wrap, or continuously while the core is cleared or in
// reset. Assumes load is a one-cycle strobe from the counter.
module rate_holder
    import frame_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  core_run,
    input  logic  load,
    input  rate_t rate_in,
    output rate_t rate_out
);

    rate_t rate_q;

    // Purpose: track the select while idle, otherwise update only on a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !core_run) begin
            rate_q <= rate_in;
        end else if (load) begin
            rate_q <= rate_in;
        end
    end

    assign rate_out = rate_q;

endmodule

// File: rtl/pc_counter.sv
// Module: pc_counter
// Instruction counter that steps once per clock and wraps after the last
// instruction of the frame length set by the active rate. Assumes BASE_LEN is
// a power of two, and that the rate input is stable within a frame.
module pc_counter
    import frame_seq_pkg::*;
#(
    parameter int BASE_LEN = 512,
    localparam int PC_W = $clog2(BASE_LEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            core_run,
    input  rate_t           rate,
    output logic [PC_W-1:0] pc,
    output logic            wrap
);

    logic [PC_W-1:0] last_pc;
    logic [PC_W-1:0] pc_q;

    // Purpose: last count of the current frame for the active rate.
    always_comb begin
        last_pc = PC_W'(frame_len(BASE_LEN, rate) - 1);
    end

    assign wrap = core_run && (pc_q == last_pc);

    // Purpose: hold at zero while cleared, else count and wrap at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n || !core_run) begin
            pc_q <= '0;
        end else if (wrap) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_q + 1'b1;
        end
    end

    assign pc = pc_q;

endmodule

// File: rtl/frame_sequencer.sv
// Module: frame_sequencer (top)
// Generates the per-sample instruction counter, a start-of-frame pulse and the
// active converter rate for a DSP core. Assumes core_run is the active-low
// clear control: it is 0 out of reset and must be 1 for the core to run.
module frame_sequencer
    import frame_seq_pkg::*;
#(
    parameter int BASE_LEN = 512,
    localparam int PC_W = $clog2(BASE_LEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      rate_sel,
    input  logic            core_run,
    output logic [PC_W-1:0] pc,
    output logic            frame_start,
    output logic [1:0]      conv_rate
);

    rate_t sel_rate;
    rate_t act_rate;
    logic  wrap;

    rate_decode #(.RSVD_AS_BASE(1'b1)) u_dec (
        .code_in (rate_sel),
        .rate_out(sel_rate)
    );

    rate_holder u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .core_run(core_run),
        .load    (wrap),
        .rate_in (sel_rate),
        .rate_out(act_rate)
    );

    pc_counter #(.BASE_LEN(BASE_LEN)) u_pc (
        .clk     (clk),
        .rst_n   (rst_n),
        .core_run(core_run),
        .rate    (act_rate),
        .pc      (pc),
        .wrap    (wrap)
    );

    // Purpose: mark instruction zero of each running frame.
    always_comb begin
        frame_start = rst_n && core_run && (pc == '0);
    end

    assign conv_rate = act_rate;

endmodule

// File: rtl/frame_sequencer_chk.sv
// Module: frame_sequencer_chk
// Assertion checker bound to frame_sequencer. It observes only the ports.
module frame_sequencer_chk #(
    parameter int BASE_LEN = 512,
    localparam int PC_W = $clog2(BASE_LEN)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      rate_sel,
    input logic            core_run,
    input logic [PC_W-1:0] pc,
    input logic            frame_start,
    input logic [1:0]      conv_rate
);

    logic [PC_W-1:0] last_now;
    logic            rate_sel_seen;

    assign last_now      = PC_W'((BASE_LEN >> conv_rate) - 1);
    assign rate_sel_seen = ^rate_sel | 1'b1;

    // R1
    pc_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rate_sel_seen |-> pc <= last_now);

    // R5
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(core_run) && core_run && pc != '0)
            |-> pc == $past(pc) + 1'b1);

    // R6
    rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(core_run) && pc != '0) |-> $stable(conv_rate));

    // R7
    clear_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(core_run)) |-> pc == '0);

    // R7
    no_pulse_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_run |-> !frame_start);

    // R8
    no_rsvd_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> conv_rate != 2'b11);

    // R5
    pulse_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> pc == '0);

endmodule

bind frame_sequencer frame_sequencer_chk #(.BASE_LEN(BASE_LEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rate_sel   (rate_sel),
    .core_run   (core_run),
    .pc         (pc),
    .frame_start(frame_start),
    .conv_rate  (conv_rate)
);

// File: tb/tb_frame_sequencer.sv
`timescale 1ns/1ps
module tb_frame_sequencer;

    localparam int BASE = 512;
    localparam int PW   = 9;

    typedef struct {
        int    pc;
        bit    fs;
        int    rate;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    rate_sel = 2'b00;
    logic          core_run = 1'b0;
    logic [PW-1:0] pc;
    logic          frame_start;
    logic [1:0]    conv_rate;

    exp_t q[$];
    exp_t cur;
    int   checks = 0;
    int   fails = 0;
    int   m_pc = 0;
    int   m_rate = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    frame_sequencer dut (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .core_run(core_run),
        .pc(pc), .frame_start(frame_start), .conv_rate(conv_rate)
    );

    function automatic int dec(input logic [1:0] s);
        return (s == 2'b11) ? 0 : int'(s);
    endfunction

    // Driver: apply inputs for one cycle and push the expected result.
    task automatic step(input bit r, input bit run, input logic [1:0] s, input string tag);
        exp_t e;
        @(negedge clk);
        #1;
        rst_n = r; core_run = run; rate_sel = s;
        if (!r || !run) begin
            m_pc = 0; m_rate = dec(s);
        end else if (m_pc == (BASE >> m_rate) - 1) begin
            m_pc = 0; m_rate = dec(s);
        end else begin
            m_pc = m_pc + 1;
        end
        e.pc = m_pc; e.fs = r && run && (m_pc == 0); e.rate = m_rate; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic steps(input int n, input bit r, input bit run, input logic [1:0] s, input string tag);
        for (int i = 0; i < n; i++) step(r, run, s, tag);
    endtask

    // Monitor: pop and compare one expected item per cycle.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            cur = q.pop_front();
            checks++;
            if (int'(pc) != cur.pc || frame_start != cur.fs || int'(conv_rate) != cur.rate) begin
                fails++;
                $display("FAIL %s: pc=%0d fs=%0b rate=%0d expected pc=%0d fs=%0b rate=%0d",
                         cur.tag, pc, frame_start, conv_rate, cur.pc, cur.fs, cur.rate);
            end
        end
    end

    initial begin
        steps(3, 1'b0, 1'b0, 2'b00, "R9");     // reset
        steps(5, 1'b1, 1'b0, 2'b10, "R7");     // cleared, select tracked
        steps(1, 1'b1, 1'b0, 2'b00, "R7");
        steps(520, 1'b1, 1'b1, 2'b00, "R1");   // base frames and a wrap
        steps(100, 1'b1, 1'b1, 2'b00, "R5");
        steps(700, 1'b1, 1'b1, 2'b01, "R6");   // mid-frame change, then R2 frames
        steps(300, 1'b1, 1'b1, 2'b01, "R2");
        steps(300, 1'b1, 1'b1, 2'b10, "R3");
        steps(1100, 1'b1, 1'b1, 2'b11, "R4");  // reserved code runs as base
        steps(10, 1'b1, 1'b0, 2'b10, "R7");    // clear mid-frame
        steps(300, 1'b1, 1'b1, 2'b10, "R8");
        steps(2, 1'b0, 1'b1, 2'b01, "R9");     // reset while running
        steps(40, 1'b1, 1'b1, 2'b01, "R2");
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule